// File: doc/BRIEF.md
# Debug-Port Memory Access Bridge

This block sits behind a boundary-scan test access port and gives an external probe a path into system memory. The port's controller supplies the current 4-bit instruction and the capture, shift and update strobes in the test-clock domain. Three instruction codes pick a data register in this block. One is a 30-bit word-address register. The other two are 32-bit data registers: one only reads memory, the other reads and writes it in the same shift. Each memory access is carried out as a single classic Wishbone transfer in the system clock domain, so memory stays reachable while the processor runs. The test clock is slower than the system clock and has no phase relation to it.

The address register steps forward by one word after every data access. A burst therefore needs one address load followed by back-to-back data shifts. Each update of the test clock side toggles a request that crosses into the system clock domain through two flops. The system side performs the write, if one is needed, moves the address on and reads the next word ahead of time. It then toggles an acknowledge that crosses back the same way. The next capture finds the next word already waiting.

Top module: `jtag_mem_bridge`

## Requirements
- R1: Instruction 4'b0101 selects the address register, 4'b0110 selects read-only access and 4'b0111 selects read-and-write access. With any other code, tdo stays low, no bus transfer starts and the address is unchanged.
- R2: An address scan shifts 30 bits least significant bit first. It returns the current word address on tdo, and its update loads the shifted-in value as the new address. The address is zero after reset.
- R3: A read-and-write scan shifts 32 bits least significant bit first. It returns the word stored at the current address, and its update writes the shifted-in word to that address.
- R4: A read-only scan returns the word at the current address and writes nothing; the data shifted in is discarded.
- R5: After each data access the address advances by one word and wraps from all ones to zero. A bus read or write of the next access therefore targets the following word.
- R6: Each bus transfer drives cyc and stb together with all four byte selects set. It holds cyc, we and the address steady until ack. we is high only when writing the shifted-in word.
- R7: A data scan made after reset and before any access has completed returns zero.
- R8: Each update on a selected register raises exactly one request. The system side accepts a request only while no transfer is in flight, and the acknowledge must return before the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| tck | input | 1 | Test clock |
| tdi | input | 1 | Serial data in |
| ir | input | 4 | Current instruction from the port controller |
| capture_dr | input | 1 | Capture state of the data-register path, sampled on tck rise |
| shift_dr | input | 1 | Shift state of the data-register path |
| update_dr | input | 1 | Update state of the data-register path |
| tdo | output | 1 | Serial data out, bit 0 of the selected register |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_sel | output | 4 | Byte selects |
| wb_adr | output | 30 | Word address |
| wb_dat_o | output | 32 | Write data |
| wb_dat_i | input | 32 | Read data |
| wb_ack | input | 1 | Transfer acknowledge |

## Verification
The hardest case to reach from the ports is a read-and-write scan whose returned word depends on a write made by an earlier scan. The checks need the word to have been prefetched after that write and carried back across both synchronisers before the capture. The stimulus writes two words, reloads the address and rewrites them with swapped patterns, checking each old value as it shifts out. It then reads them back in read-only mode. Address wrap is reached by loading the all-ones address and running one read. The prefetch-less state is reached by resetting in the middle of the run and scanning data at once.

// File: rtl/jtag_mem_bridge.sv
module jtag_mem_bridge #(
  parameter int AW = 30,
  parameter int DW = 32,
  parameter int IRW = 4,
  parameter logic [IRW-1:0] IR_ADDR = 4'b0101,
  parameter logic [IRW-1:0] IR_READ = 4'b0110,
  parameter logic [IRW-1:0] IR_RDWR = 4'b0111
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tck,
  input  logic           tdi,
  input  logic [IRW-1:0] ir,
  input  logic           capture_dr,
  input  logic           shift_dr,
  input  logic           update_dr,
  output logic           tdo,
  output logic           wb_cyc,
  output logic           wb_stb,
  output logic           wb_we,
  output logic [DW/8-1:0] wb_sel,
  output logic [AW-1:0]  wb_adr,
  output logic [DW-1:0]  wb_dat_o,
  input  logic [DW-1:0]  wb_dat_i,
  input  logic           wb_ack
);
  localparam logic [1:0] OP_ADDR = 2'd0, OP_RD = 2'd1, OP_RW = 2'd2;
  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} state_t;

  logic [AW-1:0] asr, hold_addr, addr;
  logic [DW-1:0] dsr, hold_data, rdata;
  logic [1:0]    hold_op;
  logic          req_t, ack_t, ack_s1, ack_s2;
  logic [2:0]    req_s;
  state_t        st;

  wire sel_a = (ir == IR_ADDR);
  wire sel_d = (ir == IR_READ) || (ir == IR_RDWR);
  wire busy  = req_t ^ ack_s2;
  wire go    = req_s[1] ^ req_s[2];

  assign tdo = sel_a ? asr[0] : (sel_d ? dsr[0] : 1'b0);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      asr <= '0; dsr <= '0; hold_addr <= '0; hold_data <= '0;
      hold_op <= OP_ADDR; req_t <= 1'b0; ack_s1 <= 1'b0; ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_t;
      ack_s2 <= ack_s1;
      if (capture_dr) begin
        if (sel_a) asr <= addr;
        if (sel_d) dsr <= rdata;
      end else if (shift_dr) begin
        if (sel_a) asr <= {tdi, asr[AW-1:1]};
        if (sel_d) dsr <= {tdi, dsr[DW-1:1]};
      end else if (update_dr && (sel_a || sel_d)) begin
        hold_op   <= sel_a ? OP_ADDR : ((ir == IR_RDWR) ? OP_RW : OP_RD);
        hold_addr <= asr;
        hold_data <= dsr;
        req_t     <= ~req_t;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s <= '0; st <= S_IDLE; addr <= '0; rdata <= '0; ack_t <= 1'b0;
    end else begin
      req_s <= {req_s[1:0], req_t};
      case (st)
        S_IDLE: if (go) begin
          case (hold_op)
            OP_ADDR: begin addr <= hold_addr; st <= S_RD; end
            OP_RD:   begin addr <= addr + 1'b1; st <= S_RD; end
            default: st <= S_WR;
          endcase
        end
        S_WR: if (wb_ack) begin addr <= addr + 1'b1; st <= S_RD; end
        default: if (wb_ack) begin rdata <= wb_dat_i; ack_t <= ~ack_t; st <= S_IDLE; end
      endcase
    end
  end

  assign wb_cyc   = (st != S_IDLE);
  assign wb_stb   = wb_cyc;
  assign wb_we    = (st == S_WR);
  assign wb_sel   = '1;
  assign wb_adr   = addr;
  assign wb_dat_o = hold_data;

  AST_CYC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && !wb_ack |=> wb_cyc && $stable(wb_adr) && $stable(wb_we)); // R6
  AST_SEL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc |-> wb_stb && (wb_sel == '1)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && wb_we && wb_ack |=> wb_cyc && !wb_we && (wb_adr == $past(wb_adr) + 1'b1)); // R5
  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !wb_cyc); // R8
  AST_CAPTURE_IDLE: assert property (@(posedge tck) disable iff (!rst_n)
    capture_dr && (sel_a || sel_d) |-> !busy); // R8
endmodule

// File: tb/jtag_mem_bridge_test.sv
module jtag_mem_bridge_test;
  logic clk = 0, rst_n = 0, tck = 0, tdi = 0;
  logic [3:0] ir = 4'b1111;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdo;
  logic wb_cyc, wb_stb, wb_we, wb_ack = 0;
  logic [3:0] wb_sel;
  logic [29:0] wb_adr;
  logic [31:0] wb_dat_o, wb_dat_i;
  logic [31:0] mem [16];
  int checks = 0, errors = 0, writes = 0, xfers = 0, badbus = 0;

  always #4 clk = ~clk;

  jtag_mem_bridge uut (.clk(clk), .rst_n(rst_n), .tck(tck), .tdi(tdi), .ir(ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr), .tdo(tdo),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_sel(wb_sel), .wb_adr(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack));

  assign wb_dat_i = mem[wb_adr[3:0]];
  always @(posedge clk) begin
    wb_ack <= wb_cyc && wb_stb && !wb_ack;
    if (wb_cyc && wb_stb && !wb_ack && wb_we) mem[wb_adr[3:0]] <= wb_dat_o;
    if (wb_cyc && wb_ack) xfers <= xfers + 1;
    if (wb_cyc && wb_ack && wb_we) writes <= writes + 1;
  end
  always @(negedge clk)
    if (wb_cyc && (!wb_stb || wb_sel != 4'hF)) badbus = badbus + 1;

  localparam int N = 12;
  localparam logic [3:0]  T_IR  [N] = '{4'b0101, 4'b0111, 4'b0111, 4'b0101, 4'b0111, 4'b0111,
                                        4'b0101, 4'b0110, 4'b0110, 4'b0110, 4'b0101, 4'b0110};
  localparam logic [31:0] T_DIN [N] = '{32'd1, 32'h55555555, 32'hAAAAAAAA, 32'd1, 32'hAAAAAAAA,
                                        32'h55555555, 32'd1, 32'd0, 32'd0, 32'h12345678, 32'd3, 32'd0};
  localparam logic [31:0] T_EXP [N] = '{32'd0, 32'hC0DE0001, 32'hC0DE0002, 32'd3, 32'h55555555,
                                        32'hAAAAAAAA, 32'd3, 32'hAAAAAAAA, 32'h55555555,
                                        32'hC0DE0003, 32'd4, 32'hC0DE0003};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tck_pulse;
    #43 tck = 1;
    #43 tck = 0;
  endtask

  task automatic scan(input logic [3:0] code, input logic [31:0] din, output logic [31:0] dout);
    int n;
    n = (code == 4'b0101) ? 30 : 32;
    dout = '0;
    ir = code;
    capture_dr = 1; tck_pulse; capture_dr = 0;
    shift_dr = 1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      dout[i] = tdo;
      tck_pulse;
    end
    shift_dr = 0;
    update_dr = 1; tck_pulse; update_dr = 0;
    repeat (12) tck_pulse;
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int snap;
    for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE0000 | i;
    #100 rst_n = 1;
    #20;
    check("R6 reset cyc", {31'd0, wb_cyc}, 32'd0);
    ir = 4'b0101; #1;
    check("R2 reset tdo", {31'd0, tdo}, 32'd0);

    for (int k = 0; k < N; k++) begin
      scan(T_IR[k], T_DIN[k], r);
      check($sformatf("R1 R2 R3 R4 R5 vector %0d", k), r, T_EXP[k]);
    end
    check("R3 R4 write count", writes, 4);

    snap = xfers;
    ir = 4'b0001; #1;
    check("R1 other code tdo", {31'd0, tdo}, 32'd0);
    scan(4'b0001, 32'hFFFFFFFF, r);
    check("R1 other code shift out", r, 32'd0);
    check("R1 other code no bus", xfers - snap, 0);
    scan(4'b0101, 32'h3FFFFFFF, r);
    check("R1 address kept", r, 32'd4);

    scan(4'b0110, 32'd0, r);
    check("R5 top word", r, 32'hC0DE000F);
    scan(4'b0101, 32'd0, r);
    check("R5 address wrap", r, 32'd0);

    rst_n = 0; #50 rst_n = 1; #20;
    scan(4'b0110, 32'd0, r);
    check("R7 data before prefetch", r, 32'd0);
    scan(4'b0101, 32'd0, r);
    check("R5 R2 step after reset", r, 32'd1);
    check("R6 bus strobe/select", badbus, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule